// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the serial test port of a memory device. A 16-state controller advances on every rising edge of the scan clock, steered by the mode-select input. It decides whether a scan moves bits through the 3-bit instruction register or through the data register picked by the current instruction. The data registers are a 1-bit bypass stage, a 32-bit identification register and a 107-cell boundary chain. Serial data enters on `scan_in` and leaves on `scan_out`. The output changes only on falling clock edges, and a separate enable tells the pad driver when the output is live.

The boundary chain sits on a generic parallel bus. `bnd_in` is the set of values captured from the device pins, and `bnd_out` is the set of latched update values. `bnd_drive` tells the pad logic to present `bnd_out` in place of normal function. The port has no flow control: it is a synchronous serial protocol driven by the scan clock, so valid/ready handshakes do not apply, and every input is sampled on each rising edge.

Top module: `tap_scan_ctrl`

## Requirements
- R1: An active-low `rst_n`, or any rising edge with the controller in Test-Logic-Reset, sets the instruction to identify (code 001). After reset, `scan_out_en` is low, `bnd_out` is all zeros and `bnd_drive` is low.
- R2: From any state, five consecutive rising edges with `mode_sel` high leave the controller in Test-Logic-Reset.
- R3: Capture-IR loads the pattern 001 into the instruction shift register, and that pattern is shifted out least significant bit first. The shifted-in code takes effect only at Update-IR.
- R4: With the identify instruction, a data scan shifts out the 32-bit word least significant bit first. Bit 0 is 1, bits 11:1 are the manufacturer code 00000110100, bits 28:12 are the 17-bit `DEVICE_CODE`, and bits 31:29 are `REVISION` (000).
- R5: Code 111, and every code without an assignment (010, 011, 101, 110), selects the single-bit bypass stage. That stage captures 0, so a data scan returns the input delayed by one clock.
- R6: With sample/preload (code 100) or external test (code 000), Capture-DR latches `bnd_in`. The chain then shifts out cell 0 first, and new data enters at cell 106.
- R7: Under sample/preload or external test, Update-DR copies the chain into `bnd_out`. Under sample/preload, `bnd_drive` stays low.
- R8: While the instruction is external test (000), `bnd_drive` is high, and `bnd_out` keeps the value preloaded before the instruction change.
- R9: A data scan under the identify or bypass instruction leaves `bnd_out` unchanged.
- R10: `scan_out` and `scan_out_en` change only on falling edges of `scan_clk`. `scan_out_en` is high only for the half cycles that follow a rising edge leaving the controller in Shift-DR or Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| scan_clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset to Test-Logic-Reset |
| mode_sel | input | 1 | Controller steering input, sampled on rising edges |
| scan_in | input | 1 | Serial data in |
| scan_out | output | 1 | Serial data out, updated on falling edges |
| scan_out_en | output | 1 | High while `scan_out` carries shift data (pad enable) |
| bnd_in | input | BND_LEN | Parallel values captured into the boundary chain |
| bnd_out | output | BND_LEN | Latched boundary update values |
| bnd_drive | output | 1 | High when the external-test instruction is active |

## Verification
The assertions check, on every cycle, the five-high escape to Test-Logic-Reset, the reload of the identify instruction in that state, and that the instruction and `bnd_out` hold steady outside their update states. They also check that the output enable follows the shift states across the falling edge. Only the bench's scenarios can show the serial content: the identification word, the 001 capture pattern, the one-clock bypass delay, the cell order of the boundary chain, and the correct values landing on `bnd_out` under preload and external test. The bench also shows that the output changes on the falling edge rather than the rising one.

// File: rtl/tap_scan_pkg.sv
package tap_scan_pkg;
  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_t;

  typedef enum logic [1:0] {SEL_BYP, SEL_ID, SEL_BND} dr_sel_t;

  localparam int IR_W = 3;
  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_scan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tms_i,
  output tap_state_t state_o
);
  tap_state_t nxt;

  always_comb begin
    unique case (state_o)
      ST_RESET:  nxt = tms_i ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxt = tms_i ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nxt = tms_i ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms_i ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms_i ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms_i ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms_i ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nxt = tms_i ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nxt = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms_i ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms_i ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms_i ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms_i ? ST_SEL_DR : ST_IDLE;
      default:   nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_o <= ST_RESET;
    else        state_o <= nxt;
  end
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_scan_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  tap_state_t      state_i,
  input  logic            tdi_i,
  output logic [IR_W-1:0] ir_o,
  output logic            sh_lsb_o
);
  logic [IR_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= OP_IDCODE;
      ir_o <= OP_IDCODE;
    end else begin
      unique case (state_i)
        ST_RESET: begin
          sh_q <= OP_IDCODE;
          ir_o <= OP_IDCODE;
        end
        ST_CAP_IR: sh_q <= IR_CAPTURE;
        ST_SH_IR:  sh_q <= {tdi_i, sh_q[IR_W-1:1]};
        ST_UPD_IR: ir_o <= sh_q;
        default: ;
      endcase
    end
  end

  assign sh_lsb_o = sh_q[0];
endmodule

// File: rtl/tap_bsr.sv
module tap_bsr #(
  parameter int LEN = 107
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cap_en,
  input  logic           shift_en,
  input  logic           upd_en,
  input  logic           tdi_i,
  input  logic [LEN-1:0] pins_i,
  output logic [LEN-1:0] upd_o,
  output logic           so_o
);
  logic [LEN-1:0] sh_q;

  for (genvar i = 0; i < LEN; i++) begin : g_cell
    logic feed;
    if (i == LEN - 1) begin : g_head
      assign feed = tdi_i;
    end else begin : g_body
      assign feed = sh_q[i+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q[i]  <= 1'b0;
        upd_o[i] <= 1'b0;
      end else begin
        if (cap_en)        sh_q[i] <= pins_i[i];
        else if (shift_en) sh_q[i] <= feed;
        if (upd_en)        upd_o[i] <= sh_q[i];
      end
    end
  end

  assign so_o = sh_q[0];
endmodule

// File: rtl/tap_scan_ctrl.sv
module tap_scan_ctrl
  import tap_scan_pkg::*;
#(
  parameter int          BND_LEN     = 107,
  parameter logic [16:0] DEVICE_CODE = 17'h0B5A3,
  parameter logic [10:0] MFR_CODE    = 11'b00000110100,
  parameter logic [2:0]  REVISION    = 3'b000
) (
  input  logic               scan_clk,
  input  logic               rst_n,
  input  logic               mode_sel,
  input  logic               scan_in,
  output logic               scan_out,
  output logic               scan_out_en,
  input  logic [BND_LEN-1:0] bnd_in,
  output logic [BND_LEN-1:0] bnd_out,
  output logic               bnd_drive
);
  localparam int ID_W = 32;
  localparam logic [ID_W-1:0] ID_WORD = {REVISION, DEVICE_CODE, MFR_CODE, 1'b1};

  tap_state_t      state;
  logic [IR_W-1:0] ir_q;
  logic            ir_so;
  dr_sel_t         dr_sel;
  logic [ID_W-1:0] id_sh;
  logic            byp_q;
  logic            bnd_so;
  logic            so_mux;
  logic            tdo_q, en_q;

  tap_fsm u_fsm (.clk(scan_clk), .rst_n(rst_n), .tms_i(mode_sel), .state_o(state));

  tap_ir u_ir (.clk(scan_clk), .rst_n(rst_n), .state_i(state), .tdi_i(scan_in),
               .ir_o(ir_q), .sh_lsb_o(ir_so));

  always_comb begin
    if (ir_q == OP_IDCODE)                          dr_sel = SEL_ID;
    else if (ir_q == OP_EXTEST || ir_q == OP_SAMPLE) dr_sel = SEL_BND;
    else                                            dr_sel = SEL_BYP;
  end

  tap_bsr #(.LEN(BND_LEN)) u_bsr (
    .clk(scan_clk), .rst_n(rst_n),
    .cap_en  (state == ST_CAP_DR && dr_sel == SEL_BND),
    .shift_en(state == ST_SH_DR  && dr_sel == SEL_BND),
    .upd_en  (state == ST_UPD_DR && dr_sel == SEL_BND),
    .tdi_i(scan_in), .pins_i(bnd_in), .upd_o(bnd_out), .so_o(bnd_so)
  );

  always_ff @(posedge scan_clk or negedge rst_n) begin
    if (!rst_n) begin
      id_sh <= '0;
      byp_q <= 1'b0;
    end else begin
      if (state == ST_CAP_DR && dr_sel == SEL_ID)     id_sh <= ID_WORD;
      else if (state == ST_SH_DR && dr_sel == SEL_ID) id_sh <= {scan_in, id_sh[ID_W-1:1]};
      if (state == ST_CAP_DR)                         byp_q <= 1'b0;
      else if (state == ST_SH_DR && dr_sel == SEL_BYP) byp_q <= scan_in;
    end
  end

  always_comb begin
    if (state == ST_SH_IR) so_mux = ir_so;
    else begin
      unique case (dr_sel)
        SEL_ID:  so_mux = id_sh[0];
        SEL_BND: so_mux = bnd_so;
        default: so_mux = byp_q;
      endcase
    end
  end

  always_ff @(negedge scan_clk or negedge rst_n) begin
    if (!rst_n) begin
      tdo_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      en_q  <= (state == ST_SH_DR) || (state == ST_SH_IR);
      tdo_q <= ((state == ST_SH_DR) || (state == ST_SH_IR)) ? so_mux : 1'b0;
    end
  end

  assign scan_out    = tdo_q;
  assign scan_out_en = en_q;
  assign bnd_drive   = (ir_q == OP_EXTEST);
endmodule

// File: rtl/tap_scan_chk.sv
module tap_scan_chk
  import tap_scan_pkg::*;
#(
  parameter int BND_LEN = 107
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tms,
  input logic               out_en,
  input tap_state_t         state,
  input logic [IR_W-1:0]    ir,
  input logic [BND_LEN-1:0] bnd
);
  logic [2:0] high_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              high_run <= '0;
    else if (!tms)           high_run <= '0;
    else if (high_run != 3'd7) high_run <= high_run + 3'd1;
  end

  AST_FIVE_HIGH_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (high_run >= 3'd5) |-> (state == ST_RESET)); // R2

  AST_RESET_LOADS_ID: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RESET) |=> (ir == OP_IDCODE)); // R1

  AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_UPD_IR && state != ST_RESET) |=> $stable(ir)); // R3

  AST_BND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_UPD_DR) |=> $stable(bnd)); // R9

  AST_EN_IN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    out_en == (state == ST_SH_DR || state == ST_SH_IR)); // R10
endmodule

bind tap_scan_ctrl tap_scan_chk #(.BND_LEN(BND_LEN)) u_chk (
  .clk(scan_clk), .rst_n(rst_n), .tms(mode_sel), .out_en(scan_out_en),
  .state(state), .ir(ir_q), .bnd(bnd_out)
);

// File: tb/tap_scan_ctrl_test.sv
module tap_scan_ctrl_test;
  localparam int          N   = 107;
  localparam logic [16:0] DEV = 17'h0B5A3;
  localparam logic [31:0] ID_EXP = {3'b000, DEV, 11'b00000110100, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic [N-1:0] pins = '0;
  logic scan_out, scan_out_en, bnd_drive;
  logic [N-1:0] bnd_out;
  int nchk = 0, nbad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tap_scan_ctrl #(.BND_LEN(N), .DEVICE_CODE(DEV)) uut (
    .scan_clk(clk), .rst_n(rst_n), .mode_sel(tms), .scan_in(tdi),
    .scan_out(scan_out), .scan_out_en(scan_out_en),
    .bnd_in(pins), .bnd_out(bnd_out), .bnd_drive(bnd_drive));

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic t, logic d);
    tms = t; tdi = d;
    @(posedge clk); @(negedge clk); #1;
  endtask

  function automatic logic [N-1:0] pat(int seed);
    logic [N-1:0] p;
    for (int i = 0; i < N; i++) p[i] = ((i * seed + seed / 2) % 5) < 2;
    return p;
  endfunction

  // from Idle; returns captured IR bits, ends in Idle
  task automatic load_ir(logic [2:0] code, output logic [2:0] cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) begin
      cap[i] = scan_out;
      step(i == 2, code[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  // from Idle; shifts n bits, ends in Idle; en_ok low if enable dropped
  task automatic scan_dr(logic [127:0] din, int n, output logic [127:0] dout,
                         output logic en_ok);
    dout = '0; en_ok = 1'b1;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = scan_out;
      if (scan_out_en !== 1'b1) en_ok = 1'b0;
      step(i == n - 1, din[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic t_reset;
    logic [127:0] q; logic ok;
    rst_n = 1'b0; tms = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check("R1 enable in reset", scan_out_en, 0);
    check("R1 bnd_out in reset", bnd_out, 0);
    check("R1 drive in reset", bnd_drive, 0);
    rst_n = 1'b1;
    step(1, 0); step(0, 0);
    check("R10 enable idle", scan_out_en, 0);
    scan_dr(128'h0, 32, q, ok);
    check("R4 id word after reset", q[31:0], ID_EXP);
    check("R10 enable during shift", ok, 1);
    check("R10 enable back in idle", scan_out_en, 0);
  endtask

  task automatic t_bypass;
    logic [2:0] c; logic [127:0] q; logic ok;
    load_ir(3'b111, c);
    check("R3 capture pattern", c, 3'b001);
    scan_dr(128'hB5, 8, q, ok);
    check("R5 bypass delay", q[7:0], 8'h6A);
    load_ir(3'b010, c);
    scan_dr(128'h39, 8, q, ok);
    check("R5 unassigned code bypass", q[7:0], 8'h72);
  endtask

  task automatic t_escape;
    logic [2:0] c; logic [127:0] q; logic ok;
    load_ir(3'b111, c);
    step(1, 0); step(0, 0); step(0, 0); step(0, 1);
    repeat (5) step(1, 0);
    step(0, 0);
    scan_dr(128'h0, 32, q, ok);
    check("R2 five highs then id", q[31:0], ID_EXP);
  endtask

  task automatic t_edge;
    logic [2:0] c;
    load_ir(3'b111, c);
    step(1, 0); step(0, 0); step(0, 0);
    check("R10 first bypass bit", scan_out, 0);
    tms = 1'b0; tdi = 1'b1;
    @(posedge clk); #1;
    check("R10 held across rising edge", scan_out, 0);
    @(negedge clk); #1;
    check("R10 changed on falling edge", scan_out, 1);
    step(1, 0); step(1, 0); step(0, 0);
  endtask

  task automatic t_preload;
    logic [2:0] c; logic [127:0] q; logic ok;
    pins = pat(3);
    load_ir(3'b100, c);
    check("R7 drive low under preload", bnd_drive, 0);
    scan_dr({21'h0, pat(7)}, N, q, ok);
    check("R6 captured chain", q[N-1:0], pat(3));
    check("R7 update lands", bnd_out, pat(7));
  endtask

  task automatic t_ignore;
    logic [2:0] c; logic [127:0] q; logic ok;
    load_ir(3'b111, c);
    scan_dr(128'hF, 4, q, ok);
    check("R9 bypass scan keeps bnd_out", bnd_out, pat(7));
    load_ir(3'b001, c);
    scan_dr(128'h0, 32, q, ok);
    check("R4 id word by instruction", q[31:0], ID_EXP);
    check("R9 id scan keeps bnd_out", bnd_out, pat(7));
  endtask

  task automatic t_extest;
    logic [2:0] c; logic [127:0] q; logic ok;
    load_ir(3'b000, c);
    check("R8 drive under extest", bnd_drive, 1);
    check("R8 preload retained", bnd_out, pat(7));
    pins = pat(11);
    scan_dr({21'h0, pat(13)}, N, q, ok);
    check("R6 extest capture", q[N-1:0], pat(11));
    check("R7 extest update", bnd_out, pat(13));
    load_ir(3'b111, c);
    check("R8 drive off after change", bnd_drive, 0);
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_escape();
    t_edge();
    t_preload();
    t_ignore();
    t_extest();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nbad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule